// File: doc/BRIEF.md
# Comma-Aligned 10-Bit Word Deserializer

This block sits behind a clock and data recovery stage. It receives one serial bit on each cycle of a bit-rate clock and groups the bits into 10-bit words. It watches every 10-bit window of the incoming stream for a comma, which is a 7-bit prefix of two zeros followed by five ones. When comma search is enabled, a comma found at any offset moves the word boundary onto it. The comma is then the next word presented. Any partly collected word is dropped.

Words leave on a parallel bus together with two complementary word clocks. Each clock toggles once per word, so each one runs at one twentieth of the bit rate. A new word arrives on every rising edge of either clock, and the rising edges alternate between the two clocks. A comma flag accompanies the word. A loopback select lets the receiver take its bits from the local transmit stream instead of the line. While loopback is selected, the transmit output is held high.

Top module: `comma_align_deser`

## Requirements
- R1: While reset is high and on the first cycle after it, the word output is zero, both word clocks are low and the comma flag is low.
- R2: Bit 0 of a word is the earliest bit received. Once the boundary is known, a new word is presented every 10 bit cycles. It appears one cycle after its last bit is sampled.
- R3: A word is a comma when bits 0 and 1 are 0 and bits 2 to 6 are 1. Bits 7 to 9 may hold any value.
- R4: With search enabled, a comma completed at any bit offset is presented as the very next word, one cycle after its last bit. A partial word cut short by this realignment is never presented.
- R5: With search disabled, the boundary stays where it was, even across misaligned commas, and the comma flag is low from the next cycle onward.
- R6: After the first word, exactly one word clock is high at any time. Each presented word raises exactly one clock, and the clock that rises alternates from word to word.
- R7: The comma flag is high for the whole life of a word that is a comma, was loaded with search enabled and was presented on a rising edge of the complementary clock. Otherwise it is low, and it rises only together with that clock.
- R8: With loopback high, the receiver uses the local transmit stream and the transmit output is 1. With loopback low, the line input is used and the transmit output follows the transmit input.
- R9: The word output changes only on a cycle where one of the word clocks rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-rate clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_ser_i | input | 1 | Serial line input |
| tx_ser_i | input | 1 | Local transmit serial stream |
| loop_sel_i | input | 1 | 1 selects internal loopback |
| align_en_i | input | 1 | 1 enables comma search and realignment |
| tx_ser_o | output | 1 | Transmit serial output, forced high in loopback |
| word_o | output | 10 | Assembled word, bit 0 earliest |
| wclk_o | output | 1 | Word clock |
| wclk_n_o | output | 1 | Complementary word clock |
| comma_o | output | 1 | Comma flag |

## Verification
The critical overlap is a comma that completes on the same bit cycle as the natural word boundary. Two causes then ask for a load at once, and exactly one clock edge and one word must result. The bench provokes this with commas sent back to back on the established boundary. It also sends a comma shifted 3 bits off the boundary, so that a natural load lands three cycles before the realigning one. The scoreboard predicts the exact words from its own bit history and flags a missing, extra or doubled edge through the clock-alternation and word-order checks.

// File: rtl/deser_pkg.sv
package deser_pkg;

    localparam int unsigned DFLT_WORD_W   = 10;
    localparam int unsigned DFLT_PREFIX_W = 7;

    typedef enum logic {
        LANE_LINE = 1'b0,
        LANE_LOOP = 1'b1
    } lane_sel_e;

endpackage

// File: rtl/deser_lane_mux.sv
module deser_lane_mux
    import deser_pkg::*;
(
    input  logic rx_ser_i,
    input  logic tx_ser_i,
    input  logic loop_sel_i,
    output logic bit_o,
    output logic tx_ser_o
);

    lane_sel_e lane;

    always_comb begin
        lane = lane_sel_e'(loop_sel_i);
        unique case (lane)
            LANE_LOOP: begin
                bit_o    = tx_ser_i;
                tx_ser_o = 1'b1;
            end
            default: begin
                bit_o    = rx_ser_i;
                tx_ser_o = tx_ser_i;
            end
        endcase
    end

endmodule

// File: rtl/deser_prefix_match.sv
module deser_prefix_match #(
    parameter int unsigned             PREFIX_W = 7,
    parameter logic [PREFIX_W-1:0]     PREFIX   = 7'b1111100
) (
    input  logic [PREFIX_W-1:0] win_i,
    output logic                hit_o
);

    logic [PREFIX_W-1:0] eq;

    for (genvar i = 0; i < PREFIX_W; i++) begin : g_bit
        assign eq[i] = ~(win_i[i] ^ PREFIX[i]);
    end

    assign hit_o = &eq;

endmodule

// File: rtl/deser_word_core.sv
module deser_word_core #(
    parameter int unsigned WORD_W = 10,
    localparam int unsigned CNT_W = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bit_i,
    input  logic              align_en_i,
    input  logic              hit_i,
    output logic [WORD_W-1:0] win_o,
    output logic [WORD_W-1:0] word_o,
    output logic              wclk_o,
    output logic              wclk_n_o,
    output logic              comma_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] word;
        logic              wclk;
        logic              wclkn;
        logic              flag;
    } state_t;

    state_t st_q, st_d;
    logic   realign;
    logic   boundary;

    assign win_o = {bit_i, st_q.shreg[WORD_W-1:1]};

    always_comb begin
        st_d     = st_q;
        realign  = align_en_i && hit_i;
        boundary = (st_q.cnt == LAST_BIT);

        st_d.shreg = win_o;

        if (boundary || realign) begin
            st_d.cnt   = '0;
            st_d.word  = win_o;
            st_d.wclk  = ~st_q.wclk;
            st_d.wclkn = st_q.wclk;
            st_d.flag  = realign && st_q.wclk;
        end else begin
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.flag  = st_q.flag && align_en_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o   = st_q.word;
    assign wclk_o   = st_q.wclk;
    assign wclk_n_o = st_q.wclkn;
    assign comma_o  = st_q.flag;

endmodule

// File: rtl/comma_align_deser.sv
module comma_align_deser
    import deser_pkg::*;
#(
    parameter int unsigned         WORD_W   = DFLT_WORD_W,
    parameter int unsigned         PREFIX_W = DFLT_PREFIX_W,
    parameter logic [PREFIX_W-1:0] PREFIX   = 7'b1111100
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rx_ser_i,
    input  logic              tx_ser_i,
    input  logic              loop_sel_i,
    input  logic              align_en_i,
    output logic              tx_ser_o,
    output logic [WORD_W-1:0] word_o,
    output logic              wclk_o,
    output logic              wclk_n_o,
    output logic              comma_o
);

    logic              rx_bit;
    logic              hit;
    logic [WORD_W-1:0] win;

    deser_lane_mux lane_i (
        .rx_ser_i   (rx_ser_i),
        .tx_ser_i   (tx_ser_i),
        .loop_sel_i (loop_sel_i),
        .bit_o      (rx_bit),
        .tx_ser_o   (tx_ser_o)
    );

    deser_prefix_match #(
        .PREFIX_W (PREFIX_W),
        .PREFIX   (PREFIX)
    ) match_i (
        .win_i (win[PREFIX_W-1:0]),
        .hit_o (hit)
    );

    deser_word_core #(
        .WORD_W (WORD_W)
    ) core_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .bit_i      (rx_bit),
        .align_en_i (align_en_i),
        .hit_i      (hit),
        .win_o      (win),
        .word_o     (word_o),
        .wclk_o     (wclk_o),
        .wclk_n_o   (wclk_n_o),
        .comma_o    (comma_o)
    );

endmodule

// File: rtl/comma_align_deser_chk.sv
module comma_align_deser_chk #(
    parameter int unsigned WORD_W = 10,
    localparam int unsigned GAP_W = $clog2(WORD_W) + 1
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              loop_sel_i,
    input logic              align_en_i,
    input logic              tx_ser_o,
    input logic [WORD_W-1:0] word_o,
    input logic              wclk_o,
    input logic              wclk_n_o,
    input logic              comma_o
);

    localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(WORD_W - 1);
    localparam logic [GAP_W-1:0] GAP_MAX  = {GAP_W{1'b1}};

    logic             p_wclk, p_wclkn, armed;
    logic [GAP_W-1:0] gap_q;
    logic             edge_now;

    assign edge_now = (wclk_o && !p_wclk) || (wclk_n_o && !p_wclkn);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            p_wclk  <= 1'b0;
            p_wclkn <= 1'b0;
            armed   <= 1'b0;
            gap_q   <= '0;
        end else begin
            p_wclk  <= wclk_o;
            p_wclkn <= wclk_n_o;
            if (edge_now) begin
                armed <= 1'b1;
                gap_q <= '0;
            end else if (gap_q != GAP_MAX) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_CLK_COMPLEMENT: assert property (@(posedge clk_i) disable iff (rst_i)
        armed |-> (wclk_o ^ wclk_n_o)); // R6

    AST_NO_DOUBLE_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
        !($rose(wclk_o) && $rose(wclk_n_o))); // R6

    AST_WORD_PERIOD_MAX: assert property (@(posedge clk_i) disable iff (rst_i)
        armed |-> (gap_q <= GAP_FULL)); // R2

    AST_EARLY_EDGE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed && edge_now && (gap_q != GAP_FULL)) |-> $past(align_en_i)); // R4

    AST_FLAG_OFF_DISABLED: assert property (@(posedge clk_i) disable iff (rst_i)
        !align_en_i |=> !comma_o); // R5

    AST_FLAG_RISE_ON_NCLK: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(comma_o) |-> $rose(wclk_n_o)); // R7

    AST_WORD_ON_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(word_o) |-> ($rose(wclk_o) || $rose(wclk_n_o))); // R9

    AST_TX_HELD_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        loop_sel_i |-> tx_ser_o); // R8

endmodule

bind comma_align_deser comma_align_deser_chk #(.WORD_W(WORD_W)) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .loop_sel_i (loop_sel_i),
    .align_en_i (align_en_i),
    .tx_ser_o   (tx_ser_o),
    .word_o     (word_o),
    .wclk_o     (wclk_o),
    .wclk_n_o   (wclk_n_o),
    .comma_o    (comma_o)
);

// File: tb/comma_align_deser_tb_top.sv
`timescale 1ns/1ps
module comma_align_deser_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_in = 1'b0, tx_in = 1'b0, loop_sel = 1'b0, align_en = 1'b1;
    logic       tx_o, wclk, wclk_n, comma;
    logic [9:0] word;

    always #2.5 clk = ~clk;

    comma_align_deser dut_i (
        .clk_i(clk), .rst_i(rst), .rx_ser_i(rx_in), .tx_ser_i(tx_in),
        .loop_sel_i(loop_sel), .align_en_i(align_en), .tx_ser_o(tx_o),
        .word_o(word), .wclk_o(wclk), .wclk_n_o(wclk_n), .comma_o(comma)
    );

    typedef struct { logic [9:0] w; bit en; } exp_t;
    exp_t q[$];

    int   checks = 0, errors = 0, n_flag_hi = 0, n_flag_lo = 0;
    bit   loop = 0, en = 1, locked = 0, done = 0;
    int   pos = 0;
    logic [9:0] hist = '0;
    string word_tag = "R2";

    // comma: bits 0,1 = 0 and bits 2..6 = 1 (R3)
    function automatic bit is_comma(input logic [9:0] w);
        return w[6:0] == 7'b1111100;
    endfunction

    function automatic logic [9:0] mk_comma(input logic [2:0] tail);
        return {tail, 5'b11111, 2'b00};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // driver: one bit per clock, predicts presented words
    task automatic send_bit(input logic b);
        @(posedge clk); #1;
        if (loop) begin tx_in = b; rx_in = ~b; end
        else      begin rx_in = b; tx_in = ~b; end
        loop_sel = loop;
        align_en = en;
        hist = {b, hist[9:1]};
        pos++;
        if (en && is_comma(hist)) begin
            q.push_back('{w: hist, en: 1'b1});
            pos = 0; locked = 1;
        end else if (locked && pos == 10) begin
            q.push_back('{w: hist, en: en});
            pos = 0;
        end
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) send_bit(w[i]);
    endtask

    // monitor / scoreboard
    logic       pw = 0, pwn = 0, last_n = 0, have_last = 0;
    logic [9:0] pword = '0;
    always @(negedge clk) begin
        if (rst) begin
            pw = 0; pwn = 0; have_last = 0; pword = '0;
        end else begin
            logic rp, rn, expf;
            exp_t e;
            rp = wclk && !pw;
            rn = wclk_n && !pwn;
            if (rp || rn) begin
                check(!(rp && rn), "R6", {rp, rn}, 2'b01);
                check(wclk != wclk_n, "R6", {wclk, wclk_n}, 2'b01);
                if (have_last) check(rn == !last_n, "R6", rn, !last_n);
                last_n = rn; have_last = 1;
                if (q.size() > 0) begin
                    e = q.pop_front();
                    check(word == e.w, is_comma(e.w) ? "R3" : word_tag, word, e.w);
                    expf = e.en && is_comma(e.w) && rn;
                    check(comma == expf, e.en ? "R7" : "R5", comma, expf);
                    if (is_comma(e.w) && expf) n_flag_hi++;
                    if (is_comma(e.w) && !expf) n_flag_lo++;
                end
            end else begin
                check(word == pword, "R9", word, pword);
            end
            pw = wclk; pwn = wclk_n; pword = word;
        end
    end

    task automatic check_reset_state();
        @(negedge clk);
        check(word == '0, "R1", word, 0);
        check({wclk, wclk_n} == 2'b00, "R1", {wclk, wclk_n}, 0);
        check(comma == 1'b0, "R1", comma, 0);
    endtask

    localparam logic [9:0] D1 = 10'b0101010101;
    localparam logic [9:0] D2 = 10'b1100110011;
    localparam logic [9:0] D3 = 10'b1001001001;

    initial begin
        repeat (4) @(posedge clk);
        check_reset_state();
        @(posedge clk); #1 rst = 1'b0;

        // R2 / R3: lock from idle, commas with various tails, back-to-back commas
        word_tag = "R2";
        for (int i = 0; i < 13; i++) send_bit(1'b0);
        send_word(mk_comma(3'b010));
        send_word(D1); send_word(D2);
        send_word(mk_comma(3'b101));
        send_word(D3);
        send_word(mk_comma(3'b000));
        send_word(mk_comma(3'b111));
        send_word(mk_comma(3'b011));
        send_word(D1);

        // R4: comma 3 bits off the boundary, natural load and realign close together
        word_tag = "R4";
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_word(mk_comma(3'b010));
        send_word(D2); send_word(D3);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        send_word(mk_comma(3'b110));
        send_word(mk_comma(3'b110));
        send_word(D1);

        // R5: search disabled, boundary frozen, flag forced low
        word_tag = "R5";
        en = 0;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_word(mk_comma(3'b010));
        send_word(D1); send_word(D1);
        while (pos != 0) send_bit(1'b0);
        send_word(mk_comma(3'b010));
        send_word(mk_comma(3'b101));
        send_word(D2);
        en = 1;
        word_tag = "R4";
        send_word(mk_comma(3'b010));
        send_word(mk_comma(3'b010));
        send_word(D3);

        // R8: loopback path and forced transmit output
        word_tag = "R8";
        loop = 1;
        send_bit(1'b0);
        @(negedge clk); check(tx_o == 1'b1, "R8", tx_o, 1);
        send_word(mk_comma(3'b001));
        @(negedge clk); check(tx_o == 1'b1, "R8", tx_o, 1);
        send_word(D1); send_word(mk_comma(3'b100)); send_word(D2);
        loop = 0;
        send_bit(1'b1);
        @(negedge clk); check(tx_o == tx_in, "R8", tx_o, tx_in);
        send_bit(1'b0);
        @(negedge clk); check(tx_o == tx_in, "R8", tx_o, tx_in);
        send_word(mk_comma(3'b010)); send_word(D3);

        // drain and final checks
        send_bit(1'b0); send_bit(1'b0);
        @(negedge clk);
        check(q.size() == 0, "R2", q.size(), 0);
        check(n_flag_hi > 0, "R7", n_flag_hi, 1);
        check(n_flag_lo > 0, "R7", n_flag_lo, 1);

        // R1: reset mid-run
        @(posedge clk); #1 rst = 1'b1;
        q.delete(); locked = 0; pos = 0;
        @(posedge clk);
        check_reset_state();
        @(posedge clk); #1 rst = 1'b0;
        check_reset_state();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2: watchdog expired actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule